// File: doc/BRIEF.md
# Operand Address Sequencer

This block sits beside the opcode decoder of a small CPU whose code and data share one 64K-byte memory reached over a byte-wide data bus and a 16-bit address bus. It owns the program counter. After reset it reads a two-byte start address from a fixed pair of locations. After that it waits in idle until the core asks for the next instruction. It then fetches the opcode and, according to the addressing mode decoded from that opcode, reads zero, one or two further bytes. It forms the effective address for the instruction and pulses a done flag.

Five mode codes are recognised: implied (no operand), absolute (a two-byte address, low byte first), zero page (a one-byte address with the high byte forced to zero), PC-relative (a signed byte offset used by branches) and indexed-indirect (a one-byte base plus the X register gives a pointer in page zero, and the two bytes at that pointer give the target). Memory is read combinationally: a read presented in a cycle returns its byte in the same cycle. That byte is captured at the closing clock edge.

Top module: `opnd_addr_seq`

## Requirements
- R1: While reset is held, `mem_rd` and `done` are low and `eff_addr` is zero. The asynchronous reset is released through a two-stage synchroniser. One idle cycle follows, then the block reads 0xFFFC and then 0xFFFD, and loads the PC with {byte at 0xFFFD, byte at 0xFFFC}.
- R2: In idle with `go` high, the block reads the opcode at the PC in that same cycle, samples `mode`, and advances the PC by one. Each operand byte fetch also advances the PC by one.
- R3: Mode code 1 (absolute) reads two bytes at consecutive PC values, low byte first. The effective address is {second byte, first byte}, and `done` is high in the fourth cycle counted from the opcode fetch.
- R4: Mode code 2 (zero page) reads one byte, gives the effective address {0x00, byte}, and raises `done` in the third cycle.
- R5: Mode code 3 (relative) reads one byte and adds it as a two's-complement value (-128 to +127) to the PC that points just past that byte, modulo 2^16. `done` is high in the third cycle.
- R6: Mode code 4 (indexed-indirect) reads a base byte and samples `idx_x` in that same cycle. It then reads address {0x00, (base+X) mod 256} and then {0x00, (base+X+1) mod 256}. The effective address is {second byte, first byte}, and `done` is high in the fifth cycle.
- R7: Mode codes 0, 5, 6 and 7 are implied. No operand is read, `done` is high in the cycle after the opcode fetch, and the effective address is the PC just past the opcode.
- R8: `done` is high for exactly one cycle per instruction. `eff_addr` keeps its value until the next `done`.
- R9: Changes on `go` and `mode` while an instruction is in progress have no effect on the bus sequence or on the result.
- R10: In idle with `go` low, `mem_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start the next instruction (sampled in idle) |
| mode | input | 3 | Addressing mode code, valid with `go` |
| idx_x | input | 8 | X index register value |
| rd_data | input | 8 | Byte returned by memory for `mem_addr` |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| eff_addr | output | 16 | Effective address of the current instruction |
| done | output | 1 | One-cycle pulse: `eff_addr` is valid |

## Verification
A behavioural model predicts the bus address, read strobe, done pulse and effective address for every cycle. The bench runs each mode in turn. Relative offsets of +5, -16, -128 and +127 separate sign extension from a plain unsigned add. Indexed-indirect runs use a base with no overflow, a base plus X that wraps past 0xFF, and a pointer at 0xFF whose successor must wrap to 0x00 rather than to 0x100. A run of absolute mode and a run of indexed-indirect mode keep `go` high and change `mode` to a different code while the instruction is busy, so that any late sampling of those inputs shows up. Idle gaps between instructions test that the strobe stays low and that the last effective address holds.

// File: rtl/oas_pkg.sv
`timescale 1ns/1ps
package oas_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    AM_IMP = 3'd0,
    AM_ABS = 3'd1,
    AM_ZPG = 3'd2,
    AM_REL = 3'd3,
    AM_IDX = 3'd4
  } amode_t;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_VLO,
    ST_VHI,
    ST_IDLE,
    ST_OPA,
    ST_OPB,
    ST_PTL,
    ST_PTH,
    ST_DONE
  } seq_st_t;

  typedef enum logic [2:0] {
    EA_HOLD,
    EA_NEXTPC,
    EA_ZPG,
    EA_REL,
    EA_WIDE
  } ea_sel_t;

  function automatic amode_t decode_mode(input logic [MODE_W-1:0] code);
    amode_t am;
    case (code)
      3'd1:    am = AM_ABS;
      3'd2:    am = AM_ZPG;
      3'd3:    am = AM_REL;
      3'd4:    am = AM_IDX;
      default: am = AM_IMP;
    endcase
    return am;
  endfunction

endpackage

// File: rtl/oas_rst_sync.sv
`timescale 1ns/1ps
module oas_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/oas_pc_unit.sv
`timescale 1ns/1ps
module oas_pc_unit #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] pc
);

  localparam int HW = AW - DW;
  localparam logic [AW-1:0] PC_ONE = 1;

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;
  logic          pc_en;

  always_comb begin
    pc_d  = pc_q;
    pc_en = inc | ld_lo | ld_hi;
    if (inc)   pc_d = pc_q + PC_ONE;
    if (ld_lo) pc_d = {pc_q[AW-1:DW], din};
    if (ld_hi) pc_d = {din[HW-1:0], pc_q[DW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc = pc_q;

  // R2: each fetch moves the PC forward by exactly one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> pc == $past(pc) + PC_ONE);

  // R1: vector loads and increments never coincide
  a_r1_pc_ctl_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc, ld_lo, ld_hi}));

  // R1: a low-half load leaves the high half untouched
  a_r1_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> pc[AW-1:DW] == $past(pc[AW-1:DW]));

endmodule

// File: rtl/oas_ea_unit.sv
`timescale 1ns/1ps
module oas_ea_unit
  import oas_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ea_sel_t       ea_sel,
  input  logic          opl_ld,
  input  logic          ptr_base_ld,
  input  logic          ptr_step,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] idx,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] ea,
  output logic [DW-1:0] ptr
);

  localparam int HW = AW - DW;
  localparam logic [AW-1:0] PC_ONE = 1;
  localparam logic [DW-1:0] B_ONE  = 1;

  logic [AW-1:0] ea_q, ea_d;
  logic [DW-1:0] opl_q, opl_d;
  logic [DW-1:0] ptr_q, ptr_d;
  logic          ea_en, ptr_en;
  logic [AW-1:0] pc_next;
  logic [AW-1:0] rel_off;

  always_comb begin
    pc_next = pc + PC_ONE;
    rel_off = {{HW{din[DW-1]}}, din};
  end

  // effective address next-state
  always_comb begin
    ea_en = 1'b1;
    ea_d  = ea_q;
    case (ea_sel)
      EA_NEXTPC: ea_d = pc_next;
      EA_ZPG:    ea_d = {{HW{1'b0}}, din};
      EA_REL:    ea_d = pc_next + rel_off;
      EA_WIDE:   ea_d = {din[HW-1:0], opl_q};
      default:   ea_en = 1'b0;
    endcase
  end

  // operand low-byte latch and page-zero pointer next-state
  always_comb begin
    opl_d  = opl_ld ? din : opl_q;
    ptr_en = ptr_base_ld | ptr_step;
    ptr_d  = ptr_q;
    if (ptr_base_ld)   ptr_d = din + idx;
    else if (ptr_step) ptr_d = ptr_q + B_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ea_q <= '0;
    else if (ea_en) ea_q <= ea_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opl_q <= '0;
    else if (opl_ld) opl_q <= opl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ea  = ea_q;
  assign ptr = ptr_q;

  // R4: a zero-page result has a clear high byte
  a_r4_zpg_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_sel == EA_ZPG) |=> ea[AW-1:DW] == '0);

  // R6: pointer successor wraps inside page zero
  a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step |=> ptr == DW'($past(ptr) + B_ONE));

  // R8: result holds when no new result is selected
  a_r8_ea_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_sel == EA_HOLD) |=> $stable(ea));

  // R6: the pointer pair is base+X, then base+X+1
  a_r6_ptr_base: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_base_ld |=> ptr == DW'($past(din) + $past(idx)));

endmodule

// File: rtl/oas_ctrl.sv
`timescale 1ns/1ps
module oas_ctrl
  import oas_pkg::*;
#(
  parameter int              AW       = 16,
  parameter int              DW       = 8,
  parameter logic [AW-1:0]   VEC_ADDR = 'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     pc,
  input  logic [DW-1:0]     ptr,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              done,
  output logic              pc_inc,
  output logic              pc_ld_lo,
  output logic              pc_ld_hi,
  output ea_sel_t           ea_sel,
  output logic              opl_ld,
  output logic              ptr_base_ld,
  output logic              ptr_step
);

  localparam int HW = AW - DW;
  localparam logic [AW-1:0] PC_ONE   = 1;
  localparam logic [AW-1:0] VEC_NEXT = VEC_ADDR + PC_ONE;

  seq_st_t st_q, st_d;
  amode_t  am_q, am_d;
  amode_t  am_in;
  logic    am_en;

  always_comb begin
    am_in = decode_mode(mode);
  end

  // next-state and outputs
  always_comb begin
    st_d        = st_q;
    am_d        = am_q;
    am_en       = 1'b0;
    mem_addr    = pc;
    mem_rd      = 1'b0;
    pc_inc      = 1'b0;
    pc_ld_lo    = 1'b0;
    pc_ld_hi    = 1'b0;
    ea_sel      = EA_HOLD;
    opl_ld      = 1'b0;
    ptr_base_ld = 1'b0;
    ptr_step    = 1'b0;
    case (st_q)
      ST_BOOT: st_d = ST_VLO;
      ST_VLO: begin
        mem_addr = VEC_ADDR;
        mem_rd   = 1'b1;
        pc_ld_lo = 1'b1;
        st_d     = ST_VHI;
      end
      ST_VHI: begin
        mem_addr = VEC_NEXT;
        mem_rd   = 1'b1;
        pc_ld_hi = 1'b1;
        st_d     = ST_IDLE;
      end
      ST_IDLE: begin
        if (go) begin
          mem_rd = 1'b1;
          pc_inc = 1'b1;
          am_en  = 1'b1;
          am_d   = am_in;
          if (am_in == AM_IMP) begin
            ea_sel = EA_NEXTPC;
            st_d   = ST_DONE;
          end else begin
            st_d   = ST_OPA;
          end
        end
      end
      ST_OPA: begin
        mem_rd = 1'b1;
        pc_inc = 1'b1;
        case (am_q)
          AM_ABS: begin
            opl_ld = 1'b1;
            st_d   = ST_OPB;
          end
          AM_ZPG: begin
            ea_sel = EA_ZPG;
            st_d   = ST_DONE;
          end
          AM_REL: begin
            ea_sel = EA_REL;
            st_d   = ST_DONE;
          end
          AM_IDX: begin
            ptr_base_ld = 1'b1;
            st_d        = ST_PTL;
          end
          default: st_d = ST_DONE;
        endcase
      end
      ST_OPB: begin
        mem_rd = 1'b1;
        pc_inc = 1'b1;
        ea_sel = EA_WIDE;
        st_d   = ST_DONE;
      end
      ST_PTL: begin
        mem_addr = {{HW{1'b0}}, ptr};
        mem_rd   = 1'b1;
        opl_ld   = 1'b1;
        ptr_step = 1'b1;
        st_d     = ST_PTH;
      end
      ST_PTH: begin
        mem_addr = {{HW{1'b0}}, ptr};
        mem_rd   = 1'b1;
        ea_sel   = EA_WIDE;
        st_d     = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_BOOT;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     am_q <= AM_IMP;
    else if (am_en) am_q <= am_d;
  end

  assign done = (st_q == ST_DONE);

  // R8: done never lasts two cycles
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: every result follows a memory read in the previous cycle
  a_r8_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd));

  // R3: the second absolute operand comes from the next address
  a_r3_abs_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPB) |-> mem_addr == $past(mem_addr) + PC_ONE);

  // R1: the high vector read directly follows the low vector read
  a_r1_vec_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VHI) |-> ($past(mem_rd) && $past(mem_addr) == VEC_ADDR));

  // R9: the latched mode does not change while busy
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(am_q));

  // R10: no read in idle without a request
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !go) |-> !mem_rd);

endmodule

// File: rtl/opnd_addr_seq.sv
`timescale 1ns/1ps
module opnd_addr_seq
  import oas_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] VEC_ADDR = 'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [MODE_W-1:0] mode,
  input  logic [DW-1:0]     idx_x,
  input  logic [DW-1:0]     rd_data,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic [AW-1:0]     eff_addr,
  output logic              done
);

  logic          rst_s_n;
  logic [AW-1:0] pc;
  logic [DW-1:0] ptr;
  logic          pc_inc, pc_ld_lo, pc_ld_hi;
  ea_sel_t       ea_sel;
  logic          opl_ld, ptr_base_ld, ptr_step;

  oas_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  oas_ctrl #(.AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .go          (go),
    .mode        (mode),
    .pc          (pc),
    .ptr         (ptr),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .done        (done),
    .pc_inc      (pc_inc),
    .pc_ld_lo    (pc_ld_lo),
    .pc_ld_hi    (pc_ld_hi),
    .ea_sel      (ea_sel),
    .opl_ld      (opl_ld),
    .ptr_base_ld (ptr_base_ld),
    .ptr_step    (ptr_step)
  );

  oas_pc_unit #(.AW(AW), .DW(DW)) u_pc (
    .clk   (clk),
    .rst_n (rst_s_n),
    .inc   (pc_inc),
    .ld_lo (pc_ld_lo),
    .ld_hi (pc_ld_hi),
    .din   (rd_data),
    .pc    (pc)
  );

  oas_ea_unit #(.AW(AW), .DW(DW)) u_ea (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .ea_sel      (ea_sel),
    .opl_ld      (opl_ld),
    .ptr_base_ld (ptr_base_ld),
    .ptr_step    (ptr_step),
    .din         (rd_data),
    .idx         (idx_x),
    .pc          (pc),
    .ea          (eff_addr),
    .ptr         (ptr)
  );

endmodule

// File: tb/sim_opnd_addr_seq.sv
`timescale 1ns/1ps
module sim_opnd_addr_seq;

  typedef struct {
    bit    rd;
    int    addr;
    bit    dn;
    int    ea;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  idx_x = 8'd0;
  logic [7:0]  rd_data;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [15:0] eff_addr;
  logic        done;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   chk_on = 1'b0;
  bit   ended = 1'b0;
  int   mem_gen = 0;
  int   last_ea = 0;
  int   pc_m = 0;
  exp_t eq[$];
  logic [7:0] mem [int];

  always #4 clk = ~clk;

  opnd_addr_seq u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .mode     (mode),
    .idx_x    (idx_x),
    .rd_data  (rd_data),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .eff_addr (eff_addr),
    .done     (done)
  );

  function automatic logic [7:0] rdmem(input int a);
    int k = a & 'hFFFF;
    if (mem.exists(k)) return mem[k];
    return 8'(((k & 'hFF) * 7) ^ (k >> 8) ^ 'h3C);
  endfunction

  always @(mem_addr or mem_gen) rd_data = rdmem(int'(mem_addr));

  task automatic poke(input int a, input logic [7:0] v);
    mem[a & 'hFFFF] = v;
    mem_gen++;
  endtask

  task automatic fail(input string tag, input string what, input int act, input int exp);
    n_bad++;
    $display("FAIL %s: %s actual 0x%0h expected 0x%0h", tag, what, act, exp);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // per-cycle comparison against the expected queue
  always @(negedge clk) begin
    if (chk_on) begin
      exp_t e;
      if (eq.size() > 0) e = eq.pop_front();
      else e = '{rd: 1'b0, addr: 0, dn: 1'b0, ea: 0, tag: "R10"};
      n_vec++;
      if (mem_rd !== e.rd) fail(e.tag, "mem_rd", int'(mem_rd), int'(e.rd));
      else if (e.rd && mem_addr !== e.addr[15:0]) fail(e.tag, "mem_addr", int'(mem_addr), e.addr);
      if (done !== e.dn) fail(e.dn ? e.tag : "R8", "done", int'(done), int'(e.dn));
      if (e.dn) last_ea = e.ea;
      if (eff_addr !== last_ea[15:0]) fail(e.dn ? e.tag : "R8", "eff_addr", int'(eff_addr), last_ea);
    end
  end

  // behavioural model of one instruction; drives go/mode over its cycles
  task automatic run(input logic [2:0] m, input logic [7:0] xv, input bit hold, input string tag);
    int n = 0;
    int b, lo, hi, p;
    @(posedge clk); #1;
    eq.push_back('{rd: 1'b1, addr: pc_m, dn: 1'b0, ea: 0, tag: tag}); n++;
    pc_m = (pc_m + 1) & 'hFFFF;
    case (m)
      3'd1: begin
        lo = rdmem(pc_m);
        eq.push_back('{rd: 1'b1, addr: pc_m, dn: 1'b0, ea: 0, tag: tag}); n++;
        pc_m = (pc_m + 1) & 'hFFFF;
        hi = rdmem(pc_m);
        eq.push_back('{rd: 1'b1, addr: pc_m, dn: 1'b0, ea: 0, tag: tag}); n++;
        pc_m = (pc_m + 1) & 'hFFFF;
        eq.push_back('{rd: 1'b0, addr: 0, dn: 1'b1, ea: (hi << 8) | lo, tag: tag}); n++;
      end
      3'd2: begin
        b = rdmem(pc_m);
        eq.push_back('{rd: 1'b1, addr: pc_m, dn: 1'b0, ea: 0, tag: tag}); n++;
        pc_m = (pc_m + 1) & 'hFFFF;
        eq.push_back('{rd: 1'b0, addr: 0, dn: 1'b1, ea: b, tag: tag}); n++;
      end
      3'd3: begin
        b = rdmem(pc_m);
        eq.push_back('{rd: 1'b1, addr: pc_m, dn: 1'b0, ea: 0, tag: tag}); n++;
        pc_m = (pc_m + 1) & 'hFFFF;
        if (b > 127) b = b - 256;
        eq.push_back('{rd: 1'b0, addr: 0, dn: 1'b1, ea: (pc_m + b) & 'hFFFF, tag: tag}); n++;
      end
      3'd4: begin
        b = rdmem(pc_m);
        eq.push_back('{rd: 1'b1, addr: pc_m, dn: 1'b0, ea: 0, tag: tag}); n++;
        pc_m = (pc_m + 1) & 'hFFFF;
        p = (b + int'(xv)) & 'hFF;
        lo = rdmem(p);
        eq.push_back('{rd: 1'b1, addr: p, dn: 1'b0, ea: 0, tag: tag}); n++;
        p = (p + 1) & 'hFF;
        hi = rdmem(p);
        eq.push_back('{rd: 1'b1, addr: p, dn: 1'b0, ea: 0, tag: tag}); n++;
        eq.push_back('{rd: 1'b0, addr: 0, dn: 1'b1, ea: (hi << 8) | lo, tag: tag}); n++;
      end
      default: begin
        eq.push_back('{rd: 1'b0, addr: 0, dn: 1'b1, ea: pc_m, tag: tag}); n++;
      end
    endcase
    go = 1'b1; mode = m; idx_x = xv;
    for (int k = 1; k < n; k++) begin
      @(posedge clk); #1;
      if (hold && k < n - 1) begin
        go = 1'b1;
        mode = m ^ 3'd3;
      end else begin
        go = 1'b0;
      end
    end
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    finish_up();
  end

  initial begin
    poke('hFFFC, 8'h34);
    poke('hFFFD, 8'h12);
    poke('h00FF, 8'h11);
    poke('h0000, 8'h22);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    n_vec++; if (mem_rd !== 1'b0) fail("R1", "mem_rd in reset", int'(mem_rd), 0);
    n_vec++; if (done !== 1'b0) fail("R1", "done in reset", int'(done), 0);
    n_vec++; if (eff_addr !== 16'h0) fail("R1", "eff_addr in reset", int'(eff_addr), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    chk_on = 1'b1;
    // two synchroniser cycles, one boot cycle, then the vector pair (R1)
    repeat (3) eq.push_back('{rd: 1'b0, addr: 0, dn: 1'b0, ea: 0, tag: "R1"});
    eq.push_back('{rd: 1'b1, addr: 'hFFFC, dn: 1'b0, ea: 0, tag: "R1"});
    eq.push_back('{rd: 1'b1, addr: 'hFFFD, dn: 1'b0, ea: 0, tag: "R1"});
    pc_m = 'h1234;
    repeat (5) @(posedge clk);

    run(3'd0, 8'h00, 1'b0, "R1 R2 R7");          // first fetch at reset vector
    poke(pc_m + 1, 8'hCD); poke(pc_m + 2, 8'hAB);
    run(3'd1, 8'h00, 1'b0, "R3");
    repeat (3) @(posedge clk);                   // R10 idle gap
    poke(pc_m + 1, 8'h80);
    run(3'd2, 8'h00, 1'b0, "R4");
    poke(pc_m + 1, 8'h00);
    run(3'd2, 8'h00, 1'b0, "R4");
    poke(pc_m + 1, 8'h05);
    run(3'd3, 8'h00, 1'b0, "R5");
    poke(pc_m + 1, 8'hF0);
    run(3'd3, 8'h00, 1'b0, "R5");
    poke(pc_m + 1, 8'h80);
    run(3'd3, 8'h00, 1'b0, "R5");
    poke(pc_m + 1, 8'h7F);
    run(3'd3, 8'h00, 1'b0, "R5");
    poke(pc_m + 1, 8'h20);
    run(3'd4, 8'h05, 1'b0, "R6");
    poke(pc_m + 1, 8'hF8);
    run(3'd4, 8'h10, 1'b0, "R6");
    poke(pc_m + 1, 8'hFF);
    run(3'd4, 8'h00, 1'b0, "R6");
    run(3'd6, 8'h00, 1'b0, "R7");
    run(3'd5, 8'h00, 1'b0, "R7");
    run(3'd7, 8'h00, 1'b0, "R7");
    poke(pc_m + 1, 8'h78); poke(pc_m + 2, 8'h56);
    run(3'd1, 8'h00, 1'b1, "R9");
    poke(pc_m + 1, 8'hFE);
    run(3'd4, 8'h01, 1'b1, "R9");
    poke(pc_m + 1, 8'h42);
    run(3'd2, 8'h00, 1'b1, "R9");
    repeat (4) @(posedge clk);                   // R8 hold, R10 idle
    finish_up();
  end

endmodule